// File: doc/BRIEF.md
# Memory Clearing Controller

This block wipes three on-chip memories to all-zero contents: a program store, a data store and a shared data store. The three stores differ in depth, and each one is cleared on its own. Every store has a single control bit in a small register space. Software writes 1 to the bit to begin clearing that store. The same bit then stays at 1 while the hardware steps through every word and writes zeros, and it drops back to 0 by itself once the last word has been written.

Each store sits behind its own write-capable memory port. While a store is idle, the block passes functional traffic through to it unchanged. While a store is being cleared, the clearing walk owns that store's port. A functional write is held off with a stall signal, and a functional read returns zero. Clears of different stores may overlap in time, and each finishes according to its own depth.

Top module: `zc_engine`

## Requirements
- R1: After reset all three control bits read 0, and no memory port writes unless a functional write is requested.
- R2: Control bit k sits at register address k (0 = program, 1 = data, 2 = shared). Writing 1 to an idle bit makes it read 1 from the next cycle, and clearing of that store begins in the same cycle.
- R3: While a store is being cleared, its port writes (write enable 1, data 0) one word per cycle at addresses 0, 1, … DEPTH−1 in order.
- R4: A control bit stays 1 for exactly DEPTH cycles and reads 0 in the cycle after the last word is written.
- R5: Writing 1 to a bit that is already 1 has no effect: the walk is not restarted and the bit clears at the original time.
- R6: Writing 0 to a control bit is ignored, so a running clear cannot be aborted.
- R7: The three stores can be cleared at the same time, each with its own address sequence and its own completion time.
- R8: While a store's bit is 1, a functional write to that store is stalled (stall = 1) and does not reach the memory port.
- R9: A functional read returns zero while the store's bit is 1. Otherwise it returns the memory's read data.
- R10: While a store is idle, its memory port carries the functional write enable, address and data unchanged, with stall 0.
- R11: Register address 3 holds no bit. Writes to it change nothing, and reads from it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 program, 1 data, 2 shared) |
| reg_wdata | input | 1 | Register write value |
| reg_rdata | output | 1 | Control bit at reg_addr |
| fn_we | input | 3 | Functional write request, one bit per store |
| fn_addr | input | 3*AW | Functional address, store k at bits [k*AW +: AW] |
| fn_wdata | input | 3*DW | Functional write data, per store |
| fn_stall | output | 3 | Functional write held off, per store |
| fn_rdata | output | 3*DW | Functional read data, per store |
| mem_we | output | 3 | Memory write enable, per store |
| mem_addr | output | 3*AW | Memory address, per store |
| mem_wdata | output | 3*DW | Memory write data, per store |
| mem_rdata | input | 3*DW | Memory read data, per store |

## Verification
The assertions rely on the memories accepting one write every cycle without back-pressure, on reset being held from the first clock edge, and on each depth being at least two words. The stimulus holds reset across the first edges and never withholds a memory write. Random functional traffic and register writes, including writes to address 3, writes of 0 and repeated writes of 1, arrive at any time relative to a running clear. The bench uses small depths, so many start, overlap and completion events fit into one run.

// File: rtl/zc_pkg.sv
`timescale 1ns/1ps
package zc_pkg;

    localparam int NMEM = 3;

    typedef enum logic [1:0] {
        SEL_PROG = 2'd0,
        SEL_DATA = 2'd1,
        SEL_SHRD = 2'd2,
        SEL_NONE = 2'd3
    } mem_sel_e;

    typedef struct packed {
        logic     wr;
        mem_sel_e sel;
        logic     val;
    } reg_cmd_t;

    function automatic int addr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/zc_ctrl.sv
`timescale 1ns/1ps
module zc_ctrl
    import zc_pkg::*;
#(
    parameter int       DEPTH = 1024,
    parameter int       AW    = 10,
    parameter mem_sel_e IDX   = SEL_PROG
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_cmd_t      cmd,
    output logic          busy,
    output logic [AW-1:0] walk_addr
);
    localparam int CW   = addr_bits(DEPTH);
    localparam int LAST = DEPTH - 1;

    logic [CW-1:0] cnt;
    logic          start;
    logic          at_last;

    assign start   = cmd.wr && (cmd.sel == IDX) && cmd.val && !busy;
    assign at_last = (cnt == CW'(LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (at_last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    assign walk_addr = AW'(cnt);

    p_start_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> walk_addr == '0);

    p_walk_step_r3: assert property (@(posedge clk) disable iff (rst)
        busy && !at_last |=> walk_addr == $past(walk_addr) + 1'b1);

    p_done_after_last_r4: assert property (@(posedge clk) disable iff (rst)
        busy && at_last |=> !busy);

    p_no_abort_r6: assert property (@(posedge clk) disable iff (rst)
        busy && !at_last |=> busy);

endmodule

// File: rtl/zc_mux.sv
`timescale 1ns/1ps
module zc_mux #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic [AW-1:0] walk_addr,
    input  logic          fn_we,
    input  logic [AW-1:0] fn_addr,
    input  logic [DW-1:0] fn_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          fn_stall,
    output logic [DW-1:0] fn_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    always_comb begin
        if (busy) begin
            mem_we    = 1'b1;
            mem_addr  = walk_addr;
            mem_wdata = '0;
            fn_stall  = fn_we;
            fn_rdata  = '0;
        end else begin
            mem_we    = fn_we;
            mem_addr  = fn_addr;
            mem_wdata = fn_wdata;
            fn_stall  = 1'b0;
            fn_rdata  = mem_rdata;
        end
    end

    p_zero_write_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> mem_we && mem_wdata == '0);

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        fn_we && busy |-> fn_stall);

    p_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> fn_rdata == '0);

    p_no_stall_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fn_stall);

endmodule

// File: rtl/zc_engine.sv
`timescale 1ns/1ps
module zc_engine
    import zc_pkg::*;
#(
    parameter int DEPTH_PROG = 1024,
    parameter int DEPTH_DATA = 4096,
    parameter int DEPTH_SHRD = 16384,
    parameter int DW         = 32,
    parameter int AW         = addr_bits(max3(DEPTH_PROG, DEPTH_DATA, DEPTH_SHRD))
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_wdata,
    output logic                 reg_rdata,
    input  logic [NMEM-1:0]      fn_we,
    input  logic [NMEM*AW-1:0]   fn_addr,
    input  logic [NMEM*DW-1:0]   fn_wdata,
    output logic [NMEM-1:0]      fn_stall,
    output logic [NMEM*DW-1:0]   fn_rdata,
    output logic [NMEM-1:0]      mem_we,
    output logic [NMEM*AW-1:0]   mem_addr,
    output logic [NMEM*DW-1:0]   mem_wdata,
    input  logic [NMEM*DW-1:0]   mem_rdata
);
    reg_cmd_t        cmd;
    logic [NMEM-1:0] busy;

    assign cmd.wr  = reg_wr;
    assign cmd.sel = mem_sel_e'(reg_addr);
    assign cmd.val = reg_wdata;

    for (genvar g = 0; g < NMEM; g++) begin : g_mem
        localparam int DEP = (g == 0) ? DEPTH_PROG :
                             (g == 1) ? DEPTH_DATA : DEPTH_SHRD;
        logic [AW-1:0] walk_addr;

        zc_ctrl #(
            .DEPTH (DEP),
            .AW    (AW),
            .IDX   (mem_sel_e'(g))
        ) u_ctrl (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd),
            .busy      (busy[g]),
            .walk_addr (walk_addr)
        );

        zc_mux #(
            .AW (AW),
            .DW (DW)
        ) u_mux (
            .clk       (clk),
            .rst       (rst),
            .busy      (busy[g]),
            .walk_addr (walk_addr),
            .fn_we     (fn_we[g]),
            .fn_addr   (fn_addr[g*AW +: AW]),
            .fn_wdata  (fn_wdata[g*DW +: DW]),
            .mem_rdata (mem_rdata[g*DW +: DW]),
            .fn_stall  (fn_stall[g]),
            .fn_rdata  (fn_rdata[g*DW +: DW]),
            .mem_we    (mem_we[g]),
            .mem_addr  (mem_addr[g*AW +: AW]),
            .mem_wdata (mem_wdata[g*DW +: DW])
        );
    end

    always_comb begin
        case (mem_sel_e'(reg_addr))
            SEL_PROG: reg_rdata = busy[0];
            SEL_DATA: reg_rdata = busy[1];
            SEL_SHRD: reg_rdata = busy[2];
            default:  reg_rdata = 1'b0;
        endcase
    end

    p_rise_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
        !busy[0] && !(reg_wr && reg_addr == 2'd0 && reg_wdata) |=> !busy[0]);

    p_unused_addr_r11: assert property (@(posedge clk) disable iff (rst)
        reg_addr == 2'd3 |-> !reg_rdata);

endmodule

// File: tb/sim_zc_engine.sv
`timescale 1ns/1ps
module sim_zc_engine;
    import zc_pkg::*;

    localparam int D0 = 16;
    localparam int D1 = 32;
    localparam int D2 = 64;
    localparam int DW = 16;
    localparam int AW = addr_bits(max3(D0, D1, D2));
    localparam int NM = NMEM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               reg_wr = 1'b0;
    logic [1:0]         reg_addr = '0;
    logic               reg_wdata = 1'b0;
    logic               reg_rdata;
    logic [NM-1:0]      fn_we = '0;
    logic [NM*AW-1:0]   fn_addr = '0;
    logic [NM*DW-1:0]   fn_wdata = '0;
    logic [NM-1:0]      fn_stall;
    logic [NM*DW-1:0]   fn_rdata;
    logic [NM-1:0]      mem_we;
    logic [NM*AW-1:0]   mem_addr;
    logic [NM*DW-1:0]   mem_wdata;
    logic [NM*DW-1:0]   mem_rdata = '0;

    zc_engine #(
        .DEPTH_PROG (D0),
        .DEPTH_DATA (D1),
        .DEPTH_SHRD (D2),
        .DW         (DW)
    ) u0 (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .fn_we, .fn_addr, .fn_wdata, .fn_stall, .fn_rdata,
        .mem_we, .mem_addr, .mem_wdata, .mem_rdata
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    mb [NM];
    int    mc [NM];
    int    dep [NM] = '{D0, D1, D2};
    string cur_tag = "R1";

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint exp_rd(input logic [1:0] a);
        return (a < 2'd3) ? longint'(mb[a]) : 0;
    endfunction

    task automatic check_outputs();
        chk(cur_tag, "reg_rdata", reg_rdata, exp_rd(reg_addr));
        for (int i = 0; i < NM; i++) begin
            if (mb[i] != 0) begin
                chk("R3", "mem_we busy", mem_we[i], 1);
                chk("R3", "mem_addr busy", mem_addr[i*AW +: AW], mc[i]);
                chk("R3", "mem_wdata busy", mem_wdata[i*DW +: DW], 0);
                chk("R8", "fn_stall busy", fn_stall[i], fn_we[i]);
                chk("R9", "fn_rdata busy", fn_rdata[i*DW +: DW], 0);
            end else begin
                chk("R10", "mem_we idle", mem_we[i], fn_we[i]);
                chk("R10", "mem_addr idle", mem_addr[i*AW +: AW], fn_addr[i*AW +: AW]);
                chk("R10", "mem_wdata idle", mem_wdata[i*DW +: DW], fn_wdata[i*DW +: DW]);
                chk("R10", "fn_stall idle", fn_stall[i], 0);
                chk("R9", "fn_rdata idle", fn_rdata[i*DW +: DW], mem_rdata[i*DW +: DW]);
            end
        end
    endtask

    task automatic model_tick(input logic w, input logic [1:0] a, input logic v);
        for (int i = 0; i < NM; i++) begin
            if (mb[i] != 0) begin
                if (mc[i] == dep[i] - 1) begin
                    mb[i] = 0;
                    mc[i] = 0;
                end else begin
                    mc[i] = mc[i] + 1;
                end
            end else if (w && a == 2'(i) && v) begin
                mb[i] = 1;
                mc[i] = 0;
            end
        end
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic v, input bit rnd);
        @(negedge clk);
        reg_wr    = w;
        reg_addr  = a;
        reg_wdata = v;
        if (rnd) begin
            fn_we = NM'($urandom);
            for (int i = 0; i < NM; i++) begin
                fn_addr[i*AW +: AW]   = AW'($urandom);
                fn_wdata[i*DW +: DW]  = DW'($urandom);
                mem_rdata[i*DW +: DW] = DW'($urandom);
            end
        end else begin
            fn_we = '0;
        end
        #1;
        check_outputs();
        @(posedge clk);
        model_tick(w, a, v);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NM; i++) begin
            mb[i] = 0;
            mc[i] = 0;
        end
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "mem_we in reset", mem_we, 0);
        rst = 1'b0;
        cur_tag = "R1";
        for (int a = 0; a < 3; a++) step(1'b0, 2'(a), 1'b0, 1'b0);

        // R2: start program store, then R4 on its completion
        cur_tag = "R2";
        step(1'b1, 2'd0, 1'b1, 1'b1);
        step(1'b0, 2'd0, 1'b0, 1'b1);
        cur_tag = "R4";
        repeat (D0 + 2) step(1'b0, 2'd0, 1'b0, 1'b1);

        // R7: overlapping clears of all three
        cur_tag = "R7";
        step(1'b1, 2'd0, 1'b1, 1'b1);
        step(1'b1, 2'd1, 1'b1, 1'b1);
        step(1'b1, 2'd2, 1'b1, 1'b1);
        cur_tag = "R5";
        repeat (4) step(1'b1, 2'd2, 1'b1, 1'b1);
        cur_tag = "R6";
        repeat (4) step(1'b1, 2'd1, 1'b0, 1'b1);
        step(1'b0, 2'd1, 1'b0, 1'b1);
        cur_tag = "R11";
        step(1'b1, 2'd3, 1'b1, 1'b1);
        step(1'b0, 2'd3, 1'b0, 1'b1);
        cur_tag = "R7";
        for (int k = 0; k < D2 + 4; k++) step(1'b0, 2'(k % 3), 1'b0, 1'b1);

        // R4 boundary: data store, read exactly at the end
        cur_tag = "R4";
        step(1'b1, 2'd1, 1'b1, 1'b0);
        repeat (D1) step(1'b0, 2'd1, 1'b0, 1'b0);
        step(1'b0, 2'd1, 1'b0, 1'b0);

        // random mix
        cur_tag = "R5";
        for (int k = 0; k < 3000; k++)
            step(($urandom % 6) == 0, 2'($urandom), 1'($urandom), 1'b1);

        summary();
        $finish;
    end

endmodule